// File: doc/BRIEF.md
# Indexed Register Access Port

This block is the processor-facing register access unit of a peripheral controller. A host processor reaches every register through two locations on a 16-bit bus. One address line picks the command port or the data port. An active-low chip select gates the access, and separate active-low read and write strobes set its direction. The processor first writes an 8-bit register index to the command port. It then moves one or two 16-bit words through the data port. Bit 7 of the index marks a write command; the same index with bit 7 clear is the read command for that register.

Behind the port sit four registers:

- a read-only identification word;
- a 16-bit scratch register that software can read and write freely;
- a 32-bit wide register that is moved as two 16-bit halves;
- a buffer port into a local word RAM. Each word that passes through the buffer port steps a byte pointer by two, so a block of data can be streamed after a single command.

The unit acts once on each assertion of a strobe. The bus is sampled on the block clock, and the read result is registered so that it is held stable while the read strobe stays low.

Top module: `regAccessPort`

## Requirements
- R1: While chip select (`csN`) is high, the strobes have no effect. No register, pointer or command state changes, and `rdData` holds its value.
- R2: A write strobe with `addrSel`=1 latches `wrData[7:0]` as the register index. `wrData[15:8]` is ignored.
- R3: Register indices for read/write:
  - 0x27/(none): the identification word. It has no write index, and 0xA7 is treated as unknown.
  - 0x28/0xA8: the scratch register.
  - 0x29/0xA9: the wide register.
  - 0x41/0xC1: the buffer port.
- R4: A command for a 16-bit register (identification word or scratch) serves exactly one data phase. After that phase the command is consumed, and later data phases are ignored.
- R5: A read of the identification word returns 0x61 in bits 15:8 and the revision parameter (default 0x02) in bits 7:0.
- R6: The scratch register stores any 16-bit value written to it and returns that value on a read.
- R7: The wide register takes two data phases. The first carries bits 15:0 and the second carries bits 31:16. On a write, the register changes only at the second phase. A new command given after only the first phase leaves the register unchanged.
- R8: Each buffer-port data phase moves one 16-bit word at the current pointer and advances the byte pointer by 2. The command stays valid for any number of phases. The pointer wraps to 0 after the last word of the RAM (64 words by default).
- R9: Any buffer-port command, read or write, resets the buffer pointer to 0.
- R10: The following data phases are ignored, and a read among them returns 0x0000:
  - a data phase with no valid command, or after an unknown index;
  - a data phase whose direction does not match the command's bit 7;
  - a read of the command port.
- R11: After reset, `rdData` is 0, no command is valid, the scratch and wide registers are 0, and the buffer pointer is 0.
- R12: A strobe held low for several cycles performs one access only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; the bus is sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| addrSel | input | 1 | 1 selects the command port, 0 selects the data port |
| wrData | input | 16 | Write data; a command index uses bits 7:0 |
| rdData | output | 16 | Registered read data, updated when a read strobe begins |

## Verification
The bench first writes only the low half of the wide register and then issues a fresh command. It checks that the register still holds its old value, which catches a design that commits the half-word early. It holds a buffer write strobe low for three cycles and then reads the buffer back. A design that acts on the level instead of the edge would store extra words and shift every later word out of place. It writes one word more than the RAM holds and issues a second buffer command partway through a burst, which exposes a pointer that fails to wrap or fails to reset. It also sends data phases after an unknown index, after a consumed command and in the wrong direction. A design that leaked any of these would corrupt the scratch register or return stale read data where zero is expected.

// File: rtl/regAccessPkg.sv
package regAccessPkg;

  localparam logic [7:0] ID_HIGH     = 8'h61;
  localparam logic [6:0] IDX_ID      = 7'h27;
  localparam logic [6:0] IDX_SCRATCH = 7'h28;
  localparam logic [6:0] IDX_WIDE    = 7'h29;
  localparam logic [6:0] IDX_BUF     = 7'h41;

  typedef enum logic [2:0] {
    KIND_NONE, KIND_ID, KIND_SCRATCH, KIND_WIDE, KIND_BUF
  } regKind_e;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_ID, SEL_SCRATCH, SEL_WIDE_LO, SEL_WIDE_HI, SEL_BUF
  } rdSel_e;

  // strobes from the control sequencer to the register datapath
  typedef struct packed {
    logic   scratchWr;
    logic   wideLoWr;
    logic   wideHiWr;
    logic   bufWr;
    logic   bufAdv;
    logic   ptrClr;
    logic   rdLoad;
    rdSel_e rdSel;
  } strobe_t;

  // bit 7 marks a write; the identification word has no write index
  function automatic regKind_e decodeIdx(input logic [7:0] idx);
    regKind_e kind;
    kind = KIND_NONE;
    case (idx[6:0])
      IDX_ID:      kind = idx[7] ? KIND_NONE : KIND_ID;
      IDX_SCRATCH: kind = KIND_SCRATCH;
      IDX_WIDE:    kind = KIND_WIDE;
      IDX_BUF:     kind = KIND_BUF;
      default:     kind = KIND_NONE;
    endcase
    return kind;
  endfunction

endpackage

// File: rtl/regAccessCtrl.sv
module regAccessCtrl
  import regAccessPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       rdN,
  input  logic       wrN,
  input  logic       addrSel,
  input  logic [7:0] cmdByte,
  output strobe_t    strb
);

  logic     rdPrev, wrPrev;
  logic     rdAct, wrAct, rdEvt, wrEvt;
  regKind_e cmdKind, cmdKindNext;
  logic     cmdWrite, cmdWriteNext;
  logic     widePhase, widePhaseNext;
  regKind_e newKind;

  assign rdAct   = !csN && !rdN;
  assign wrAct   = !csN && !wrN;
  assign wrEvt   = wrAct && !wrPrev;
  assign rdEvt   = rdAct && !rdPrev && !wrAct;
  assign newKind = decodeIdx(cmdByte);

  always_comb begin
    strb          = '0;
    strb.rdSel    = SEL_ZERO;
    cmdKindNext   = cmdKind;
    cmdWriteNext  = cmdWrite;
    widePhaseNext = widePhase;
    if (wrEvt && addrSel) begin
      cmdKindNext   = newKind;
      cmdWriteNext  = cmdByte[7];
      widePhaseNext = 1'b0;
      strb.ptrClr   = (newKind == KIND_BUF);
    end else if (wrEvt && cmdWrite) begin
      case (cmdKind)
        KIND_SCRATCH: begin
          strb.scratchWr = 1'b1;
          cmdKindNext    = KIND_NONE;
        end
        KIND_WIDE: begin
          if (!widePhase) begin
            strb.wideLoWr = 1'b1;
            widePhaseNext = 1'b1;
          end else begin
            strb.wideHiWr = 1'b1;
            cmdKindNext   = KIND_NONE;
          end
        end
        KIND_BUF: begin
          strb.bufWr  = 1'b1;
          strb.bufAdv = 1'b1;
        end
        default: ;
      endcase
    end else if (rdEvt) begin
      strb.rdLoad = 1'b1;
      if (!addrSel && !cmdWrite) begin
        case (cmdKind)
          KIND_ID: begin
            strb.rdSel  = SEL_ID;
            cmdKindNext = KIND_NONE;
          end
          KIND_SCRATCH: begin
            strb.rdSel  = SEL_SCRATCH;
            cmdKindNext = KIND_NONE;
          end
          KIND_WIDE: begin
            if (!widePhase) begin
              strb.rdSel    = SEL_WIDE_LO;
              widePhaseNext = 1'b1;
            end else begin
              strb.rdSel  = SEL_WIDE_HI;
              cmdKindNext = KIND_NONE;
            end
          end
          KIND_BUF: begin
            strb.rdSel  = SEL_BUF;
            strb.bufAdv = 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev    <= 1'b0;
      wrPrev    <= 1'b0;
      cmdKind   <= KIND_NONE;
      cmdWrite  <= 1'b0;
      widePhase <= 1'b0;
    end else begin
      rdPrev    <= rdAct;
      wrPrev    <= wrAct;
      cmdKind   <= cmdKindNext;
      cmdWrite  <= cmdWriteNext;
      widePhase <= widePhaseNext;
    end
  end

endmodule

// File: rtl/regAccessDatapath.sv
module regAccessDatapath
  import regAccessPkg::*;
#(
  parameter logic [7:0] REVISION  = 8'h02,
  parameter int         BUF_WORDS = 64,
  localparam int        WORD_W    = $clog2(BUF_WORDS),
  localparam int        PTR_W     = WORD_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [15:0]      wrData,
  output logic [15:0]      rdData,
  output logic [PTR_W-1:0] bufPtr,
  output logic [31:0]      wideReg
);

  logic [15:0]       scratchReg;
  logic [15:0]       wideStage;
  logic [15:0]       bufMem [BUF_WORDS];
  logic [WORD_W-1:0] wordIdx;
  logic [15:0]       rdMux;

  assign wordIdx = bufPtr[PTR_W-1:1];

  always_comb begin
    case (strb.rdSel)
      SEL_ID:      rdMux = {ID_HIGH, REVISION};
      SEL_SCRATCH: rdMux = scratchReg;
      SEL_WIDE_LO: rdMux = wideReg[15:0];
      SEL_WIDE_HI: rdMux = wideReg[31:16];
      SEL_BUF:     rdMux = bufMem[wordIdx];
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strb.bufWr) bufMem[wordIdx] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scratchReg <= '0;
      wideStage  <= '0;
      wideReg    <= '0;
      bufPtr     <= '0;
      rdData     <= '0;
    end else begin
      if (strb.scratchWr) scratchReg <= wrData;
      if (strb.wideLoWr)  wideStage  <= wrData;
      if (strb.wideHiWr)  wideReg    <= {wrData, wideStage};
      if (strb.ptrClr)      bufPtr <= '0;
      else if (strb.bufAdv) bufPtr <= bufPtr + PTR_W'(2);
      if (strb.rdLoad) rdData <= rdMux;
    end
  end

endmodule

// File: rtl/regAccessPort.sv
module regAccessPort
  import regAccessPkg::*;
#(
  parameter logic [7:0] REVISION  = 8'h02,
  parameter int         BUF_WORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        rdN,
  input  logic        wrN,
  input  logic        addrSel,
  input  logic [15:0] wrData,
  output logic [15:0] rdData
);

  localparam int PTR_W = $clog2(BUF_WORDS) + 1;

  strobe_t          strb;
  logic [PTR_W-1:0] bufPtr;
  logic [31:0]      wideReg;

  regAccessCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csN     (csN),
    .rdN     (rdN),
    .wrN     (wrN),
    .addrSel (addrSel),
    .cmdByte (wrData[7:0]),
    .strb    (strb)
  );

  regAccessDatapath #(
    .REVISION  (REVISION),
    .BUF_WORDS (BUF_WORDS)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .wrData  (wrData),
    .rdData  (rdData),
    .bufPtr  (bufPtr),
    .wideReg (wideReg)
  );

endmodule

// File: rtl/regAccessChecker.sv
module regAccessChecker
  import regAccessPkg::*;
#(
  parameter int PTR_W = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic [15:0]      rdData,
  input strobe_t          strb,
  input logic [PTR_W-1:0] bufPtr,
  input logic [31:0]      wideReg
);

  assert_cs_gate_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(csN) |-> ($stable(rdData) && $stable(bufPtr) && $stable(wideReg)));

  assert_id_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && strb.rdSel == SEL_ID) |=> rdData[15:8] == ID_HIGH);

  assert_wide_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wideHiWr |=> $stable(wideReg));

  assert_ptr_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bufAdv && !strb.ptrClr) |=> bufPtr == $past(bufPtr) + PTR_W'(2));

  assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrClr |=> bufPtr == '0);

  assert_zero_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLoad && strb.rdSel == SEL_ZERO) |=> rdData == 16'h0000);

  assert_one_access_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.scratchWr, strb.wideLoWr, strb.wideHiWr, strb.bufWr, strb.rdLoad}));

endmodule

bind regAccessPort regAccessChecker #(.PTR_W(PTR_W)) i_checker (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .rdData  (rdData),
  .strb    (strb),
  .bufPtr  (bufPtr),
  .wideReg (wideReg)
);

// File: tb/test_regAccessPort.sv
`timescale 1ns/1ps
module test_regAccessPort;

  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, rdN = 1'b1, wrN = 1'b1, addrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [15:0] bufModel [WORDS];
  logic [15:0] scratchModel;
  logic [31:0] wideModel;

  regAccessPort i_regAccessPort (
    .clk(clk), .rstN(rstN), .csN(csN), .rdN(rdN), .wrN(wrN),
    .addrSel(addrSel), .wrData(wrData), .rdData(rdData)
  );

  always #2 clk = ~clk;

  function automatic logic [15:0] expId();
    return 16'h6102;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic sel, input logic [15:0] d, input int hold = 1);
    @(negedge clk);
    csN = 1'b0; wrN = 1'b0; addrSel = sel; wrData = d;
    repeat (hold) @(negedge clk);
    csN = 1'b1; wrN = 1'b1;
    @(negedge clk);
  endtask

  task automatic busRead(input logic sel, output logic [15:0] q);
    @(negedge clk);
    csN = 1'b0; rdN = 1'b0; addrSel = sel;
    @(negedge clk);
    q = rdData;
    csN = 1'b1; rdN = 1'b1;
    @(negedge clk);
  endtask

  task automatic readReg(input logic [7:0] idx, output logic [15:0] q);
    busWrite(1'b1, {8'h00, idx});
    busRead(1'b0, q);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] q, lo, hi;
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 rdData after reset", rdData, 0);
    busRead(1'b0, q);
    check("R11 no valid command after reset", q, 0);
    readReg(8'h28, q);
    check("R11 scratch reset", q, 0);
    readReg(8'h29, lo); busRead(1'b0, hi);
    check("R11 wide reset", {hi, lo}, 0);

    // R5 identification word
    readReg(8'h27, q);
    check("R5 id word", q, expId());

    // R2 upper byte of command ignored, R6 scratch
    busWrite(1'b1, 16'h55A8);
    busWrite(1'b0, 16'hBEEF);
    readReg(8'h28, q);
    check("R2 upper command byte ignored / R6 scratch", q, 16'hBEEF);
    scratchModel = 16'hBEEF;

    // R4 command consumed after one phase
    busWrite(1'b1, 16'h00A8);
    busWrite(1'b0, 16'h1111);
    busWrite(1'b0, 16'h2222);
    readReg(8'h28, q);
    check("R4 second phase ignored", q, 16'h1111);
    busRead(1'b0, q);
    check("R4 read after consumed command", q, 0);
    scratchModel = 16'h1111;

    // R1 chip select gating
    busWrite(1'b1, 16'h00A8);
    @(negedge clk); wrN = 1'b0; addrSel = 1'b0; wrData = 16'hDEAD;
    @(negedge clk); wrN = 1'b1; @(negedge clk);
    busWrite(1'b0, 16'h3333);
    readReg(8'h28, q);
    check("R1 write with csN high ignored", q, 16'h3333);
    @(negedge clk); rdN = 1'b0; addrSel = 1'b0;
    @(negedge clk); rdN = 1'b1;
    check("R1 rdData held with csN high", rdData, 16'h3333);
    scratchModel = 16'h3333;

    // R3/R10 write to id index is unknown, mismatch, command port read
    busWrite(1'b1, 16'h00A7);
    busWrite(1'b0, 16'h7777);
    busRead(1'b0, q);
    check("R3 write index of id is unknown, read gives 0", q, 0);
    busWrite(1'b1, 16'h0028);
    busWrite(1'b0, 16'h9999);
    busRead(1'b0, q);
    check("R10 direction mismatch write ignored", q, scratchModel);
    busRead(1'b1, q);
    check("R10 command port read returns 0", q, 0);
    busWrite(1'b1, 16'h0033);
    busRead(1'b0, q);
    check("R10 unknown index read returns 0", q, 0);

    // R7 wide register
    busWrite(1'b1, 16'h00A9);
    busWrite(1'b0, 16'h5678);
    busWrite(1'b0, 16'h1234);
    readReg(8'h29, lo); busRead(1'b0, hi);
    check("R7 wide write/read", {hi, lo}, 32'h12345678);
    busWrite(1'b1, 16'h00A9);
    busWrite(1'b0, 16'hAAAA);
    readReg(8'h29, lo); busRead(1'b0, hi);
    check("R7 half write does not commit", {hi, lo}, 32'h12345678);
    wideModel = 32'h12345678;

    // R12 held strobe, R8 buffer port
    busWrite(1'b1, 16'h00C1);
    busWrite(1'b0, 16'hA0A0, 3);
    busWrite(1'b0, 16'hB0B0);
    readReg(8'h41, q);
    check("R12 held strobe writes one word", q, 16'hA0A0);
    busRead(1'b0, q);
    check("R8 pointer advances by one word", q, 16'hB0B0);

    // R8 wrap
    busWrite(1'b1, 16'h00C1);
    for (int i = 0; i <= WORDS; i++) begin
      logic [15:0] v;
      v = 16'(i * 16'h0101 + 16'h0011);
      busWrite(1'b0, v);
      bufModel[i % WORDS] = v;
    end
    readReg(8'h41, q);
    check("R8 pointer wraps to word 0", q, bufModel[0]);
    busRead(1'b0, q);
    check("R8 word 1 after wrap", q, bufModel[1]);

    // R9 pointer reset by new command mid burst
    busWrite(1'b1, 16'h00C1);
    busWrite(1'b0, 16'h0001); busWrite(1'b0, 16'h0002);
    busWrite(1'b1, 16'h00C1);
    busWrite(1'b0, 16'hCAFE);
    bufModel[0] = 16'hCAFE; bufModel[1] = 16'h0002;
    readReg(8'h41, q);
    check("R9 new command restarts at word 0", q, 16'hCAFE);
    busRead(1'b0, q);
    check("R9 word 1 kept", q, 16'h0002);

    // random mix
    for (int it = 0; it < 120; it++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: begin
          scratchModel = 16'($urandom);
          busWrite(1'b1, {8'($urandom), 8'hA8});
          busWrite(1'b0, scratchModel);
        end
        1: begin
          readReg(8'h28, q);
          check("R6 random scratch read", q, scratchModel);
        end
        2: begin
          wideModel = $urandom;
          busWrite(1'b1, 16'h00A9);
          busWrite(1'b0, wideModel[15:0]);
          busWrite(1'b0, wideModel[31:16]);
          readReg(8'h29, lo); busRead(1'b0, hi);
          check("R7 random wide", {hi, lo}, wideModel);
        end
        default: begin
          int n;
          n = int'($urandom_range(1, 8));
          busWrite(1'b1, 16'h00C1);
          for (int k = 0; k < n; k++) begin
            bufModel[k] = 16'($urandom);
            busWrite(1'b0, bufModel[k]);
          end
          busWrite(1'b1, 16'h0041);
          for (int k = 0; k < n; k++) begin
            busRead(1'b0, q);
            check("R8 random buffer burst", q, bufModel[k]);
          end
        end
      endcase
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule